// File: doc/BRIEF.md
# MDIO Management Slave with Extended Register Mode

This block is the slave end of a two-wire management bus. It runs directly on the management clock and decodes serial frames on the data line. Each frame carries a long run of ones for synchronisation, a start pattern, a read or write opcode, a 5-bit device address, a 5-bit register address, a turnaround and 16 data bits. The block drives the data line only while it returns read data. At every other time it releases the line, and a pull-up holds the bus high.

A static mode input selects how frames are decoded. In standard mode a frame targets one of `NUM_PORTS` ports, whose device addresses start at `PORT_BASE`. Only a small set of 16-bit registers answers on each port. In extended mode, two device-address bits must carry a fixed signature. The other three device-address bits join the register field to form an 8-bit index into a 256-entry space of byte-wide registers. Byte data travels in the low half of the 16-bit data field.

The register contents live outside the block. The block presents an address, write data and a one-cycle write strobe, and it takes read data back combinationally.

Top module: `mdio_xreg_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones are sampled and are followed by the start bits 0 then 1. If a 0 arrives after fewer than 32 ones, the whole frame is discarded.
- R2: Opcode 10 (first bit first) is a read and opcode 01 is a write. The codes 00 and 11 abort the frame, so nothing is written and nothing is driven.
- R3: In standard mode, a device address `PORT_BASE + k` with `k < NUM_PORTS` selects port k. The register bus address is then `{k[2:0], reg[4:0]}`.
- R4: In standard mode only register numbers 0 to 5, 29 and 31 exist. A read of any other register on a selected port returns 0x0000, and a write to one produces no write strobe.
- R5: In extended mode a frame is selected only when device-address bits [2:1] equal 11. The bus address is then `{phy[4:3], phy[0], reg[4:0]}`. Frames without this signature are neither driven nor written.
- R6: In extended mode, read data goes out with bits [15:8] forced to zero, and write data reaches the bus with bits [15:8] zero and bits [7:0] taken from the frame.
- R7: On a selected read, the slave leaves the line released for the first turnaround bit. It drives 0 for the second turnaround bit, then drives D15 down to D0, one per clock. It releases the line after D0. All changes are made after the rising clock edge.
- R8: On a selected write to an existing register, `reg_we_o` pulses for exactly one cycle, in the cycle after D0 is sampled, with the address and the 16 sampled bits (most significant bit first) presented at the same time.
- R9: After reset, between frames and for unselected device addresses, `mdio_oe_o` stays low.
- R10: When the start pattern is broken (a 0 follows the preamble ones where a 1 is due), the frame is discarded. The slave then accepts the next frame that begins with 32 ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Management clock; the line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | Static mode select: 0 standard, 1 extended |
| mdio_i | input | 1 | Sampled value of the data line |
| mdio_o | output | 1 | Value driven on the data line while enabled |
| mdio_oe_o | output | 1 | Output enable for the data line |
| reg_addr_o | output | 8 | Register bus address |
| reg_wdata_o | output | 16 | Register bus write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 16 | Register bus read data, valid for the current address |

## Verification
Two things can happen in the same clock cycle: the write strobe of one frame, and the first preamble bit of the next frame when frames follow each other with no gap. The bench sends a write frame and starts a read frame straight after it. It then judges whether the read returns the value just written and whether the strobe still appears exactly once. A second coincidence is the release of the line after D0 and the first sampled bit of the next frame's preamble. This is judged by the next read frame working correctly.

// File: rtl/mdio_xreg_pkg.sv
package mdio_xreg_pkg;
  localparam int unsigned PRE_LEN = 32;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned FLD_W   = 5;
  localparam int unsigned ADDR_W  = 8;

  typedef enum logic [2:0] {
    ST_PRE, ST_SOF, ST_OP, ST_PHY, ST_REG, ST_TA, ST_DATA
  } frm_state_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  function automatic logic std_reg_exists(input logic [4:0] r);
    return (r <= 5'd5) || (r == 5'd29) || (r == 5'd31);
  endfunction
endpackage

// File: rtl/mdio_xreg_decode.sv
module mdio_xreg_decode
  import mdio_xreg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 5,
  parameter logic [4:0]  PORT_BASE = 5'd1
) (
  input  logic              ext_mode_i,
  input  logic [FLD_W-1:0]  phy_i,
  input  logic [FLD_W-1:0]  reg_i,
  output logic              sel_o,
  output logic              reg_ok_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [5:0] NP = 6'(NUM_PORTS);

  logic [5:0] port_off;
  logic       port_hit;

  assign port_off = {1'b0, phy_i} - {1'b0, PORT_BASE};
  assign port_hit = (phy_i >= PORT_BASE) && (port_off < NP);

  always_comb begin
    if (ext_mode_i) begin
      sel_o    = (phy_i[2:1] == 2'b11);
      reg_ok_o = 1'b1;
      addr_o   = {phy_i[4:3], phy_i[0], reg_i};
    end else begin
      sel_o    = port_hit;
      reg_ok_o = std_reg_exists(reg_i);
      addr_o   = {port_off[2:0], reg_i};
    end
  end
endmodule

// File: rtl/mdio_xreg_frame.sv
module mdio_xreg_frame
  import mdio_xreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  input  logic              sel_i,
  input  logic              reg_ok_i,
  output logic [FLD_W-1:0]  phy_o,
  output logic [FLD_W-1:0]  reg_o,
  output logic              load_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [5:0] PRE_CNT = 6'(PRE_LEN);

  frm_state_e        state_q;
  logic [5:0]        cnt_q;
  logic [1:0]        op_q;
  logic [FLD_W-1:0]  phy_q, reg_q;
  logic [DATA_W-1:0] sh_q;
  logic              we_q;

  assign phy_o   = phy_q;
  assign reg_o   = reg_q;
  assign we_o    = we_q;
  assign wdata_o = sh_q;
  // end of first turnaround bit: read data must be captured now
  assign load_o  = (state_q == ST_TA) && (cnt_q == 6'd0) && (op_q == OP_RD) && sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PRE;
      cnt_q   <= '0;
      op_q    <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      sh_q    <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      unique case (state_q)
        ST_PRE: begin
          if (mdio_i) begin
            if (cnt_q != PRE_CNT) cnt_q <= cnt_q + 6'd1;
          end else if (cnt_q == PRE_CNT) begin
            state_q <= ST_SOF;
            cnt_q   <= '0;
          end else begin
            cnt_q <= '0;
          end
        end
        ST_SOF: begin
          cnt_q   <= '0;
          state_q <= mdio_i ? ST_OP : ST_PRE;
        end
        ST_OP: begin
          op_q <= {op_q[0], mdio_i};
          if (cnt_q == 6'd1) begin
            cnt_q   <= '0;
            state_q <= ({op_q[0], mdio_i} == OP_RD || {op_q[0], mdio_i} == OP_WR)
                       ? ST_PHY : ST_PRE;
          end else begin
            cnt_q <= cnt_q + 6'd1;
          end
        end
        ST_PHY: begin
          phy_q <= {phy_q[FLD_W-2:0], mdio_i};
          if (cnt_q == 6'(FLD_W-1)) begin
            cnt_q   <= '0;
            state_q <= ST_REG;
          end else begin
            cnt_q <= cnt_q + 6'd1;
          end
        end
        ST_REG: begin
          reg_q <= {reg_q[FLD_W-2:0], mdio_i};
          if (cnt_q == 6'(FLD_W-1)) begin
            cnt_q   <= '0;
            state_q <= ST_TA;
          end else begin
            cnt_q <= cnt_q + 6'd1;
          end
        end
        ST_TA: begin
          if (cnt_q == 6'd1) begin
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end else begin
            cnt_q <= cnt_q + 6'd1;
          end
        end
        ST_DATA: begin
          sh_q <= {sh_q[DATA_W-2:0], mdio_i};
          if (cnt_q == 6'(DATA_W-1)) begin
            cnt_q   <= '0;
            state_q <= ST_PRE;
            we_q    <= (op_q == OP_WR) && sel_i && reg_ok_i;
          end else begin
            cnt_q <= cnt_q + 6'd1;
          end
        end
        default: begin
          state_q <= ST_PRE;
          cnt_q   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/mdio_xreg_tx.sv
module mdio_xreg_tx
  import mdio_xreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam logic [4:0] RUN = 5'(DATA_W + 1);

  logic [DATA_W:0] sh_q;
  logic [4:0]      cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= {1'b0, data_i};  // turnaround 0, then data MSB first
      cnt_q <= RUN;
    end else if (cnt_q != 5'd0) begin
      sh_q  <= {sh_q[DATA_W-1:0], 1'b0};
      cnt_q <= cnt_q - 5'd1;
    end
  end

  assign mdio_o    = sh_q[DATA_W];
  assign mdio_oe_o = (cnt_q != 5'd0);
endmodule

// File: rtl/mdio_xreg_slave.sv
module mdio_xreg_slave
  import mdio_xreg_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 5,
  parameter logic [4:0]  PORT_BASE = 5'd1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ext_mode_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic [7:0]  reg_addr_o,
  output logic [15:0] reg_wdata_o,
  output logic        reg_we_o,
  input  logic [15:0] reg_rdata_i
);
  logic [FLD_W-1:0]  phy, rg;
  logic              sel, reg_ok, load;
  logic [DATA_W-1:0] wdata, rd_word;

  mdio_xreg_decode #(.NUM_PORTS(NUM_PORTS), .PORT_BASE(PORT_BASE)) u_decode (
    .ext_mode_i (ext_mode_i),
    .phy_i      (phy),
    .reg_i      (rg),
    .sel_o      (sel),
    .reg_ok_o   (reg_ok),
    .addr_o     (reg_addr_o)
  );

  mdio_xreg_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mdio_i   (mdio_i),
    .sel_i    (sel),
    .reg_ok_i (reg_ok),
    .phy_o    (phy),
    .reg_o    (rg),
    .load_o   (load),
    .we_o     (reg_we_o),
    .wdata_o  (wdata)
  );

  always_comb begin
    if (!reg_ok)         rd_word = '0;
    else if (ext_mode_i) rd_word = {8'h00, reg_rdata_i[7:0]};
    else                 rd_word = reg_rdata_i;
  end

  assign reg_wdata_o = ext_mode_i ? {8'h00, wdata[7:0]} : wdata;

  mdio_xreg_tx u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .data_i    (rd_word),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );
endmodule

// File: rtl/mdio_xreg_slave_chk.sv
module mdio_xreg_slave_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ext_mode_i,
  input logic        mdio_o,
  input logic        mdio_oe_o,
  input logic [7:0]  reg_addr_o,
  input logic [15:0] reg_wdata_o,
  input logic        reg_we_o
);
  logic [4:0] oe_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        oe_run_q <= '0;
    else if (mdio_oe_o) oe_run_q <= (oe_run_q == 5'd31) ? oe_run_q : oe_run_q + 5'd1;
    else                oe_run_q <= '0;
  end

  AST_TA_DRIVES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o); // R7
  AST_OE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> oe_run_q <= 5'd16); // R7
  AST_EXT_RD_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && mdio_oe_o && oe_run_q >= 5'd1 && oe_run_q <= 5'd8) |-> !mdio_o); // R6
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R8
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && mdio_oe_o)); // R9
  AST_STD_WE_EXISTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && !ext_mode_i) |->
      (reg_addr_o[4:0] <= 5'd5 || reg_addr_o[4:0] == 5'd29 || reg_addr_o[4:0] == 5'd31)); // R4
  AST_EXT_WDATA_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && ext_mode_i) |-> reg_wdata_o[15:8] == 8'h00); // R6
endmodule

bind mdio_xreg_slave mdio_xreg_slave_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ext_mode_i  (ext_mode_i),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o),
  .reg_addr_o  (reg_addr_o),
  .reg_wdata_o (reg_wdata_o),
  .reg_we_o    (reg_we_o)
);

// File: tb/mdio_xreg_slave_bench.sv
module mdio_xreg_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0;
  logic        drv_en = 1'b0, drv_val = 1'b1;
  logic        dut_o, dut_oe, we;
  logic [7:0]  addr;
  logic [15:0] wdata, rdata;
  logic        line;

  logic [15:0] std_mem [256];
  logic [15:0] ext_mem [256];
  int          wr_cnt = 0;
  logic [7:0]  last_addr;
  logic [15:0] last_data;
  int          checks = 0, fails = 0;

  always #2 clk = ~clk;

  assign line  = dut_oe ? dut_o : (drv_en ? drv_val : 1'b1);
  assign rdata = ext_mode ? ext_mem[addr] : std_mem[addr];

  mdio_xreg_slave u_mdio_xreg_slave (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext_mode), .mdio_i(line),
    .mdio_o(dut_o), .mdio_oe_o(dut_oe), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata)
  );

  always @(posedge clk) if (we) begin
    wr_cnt    <= wr_cnt + 1;
    last_addr <= addr;
    last_data <= wdata;
    if (ext_mode) ext_mem[addr] <= wdata;
    else          std_mem[addr] <= wdata;
  end

  task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic b);
    @(negedge clk); drv_en = 1'b1; drv_val = b;
  endtask

  task automatic header(input int pre, input logic [1:0] sof, input logic [1:0] op,
                        input logic [4:0] phy, input logic [4:0] rg);
    for (int i = 0; i < pre; i++) send(1'b1);
    send(sof[1]); send(sof[0]);
    send(op[1]);  send(op[0]);
    for (int i = 4; i >= 0; i--) send(phy[i]);
    for (int i = 4; i >= 0; i--) send(rg[i]);
  endtask

  task automatic wr_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d);
    header(32, 2'b01, op, phy, rg);
    send(1'b1); send(1'b0);
    for (int i = 15; i >= 0; i--) send(d[i]);
    @(negedge clk); drv_en = 1'b0;
  endtask

  task automatic rd_frame(input logic [4:0] phy, input logic [4:0] rg, output logic [15:0] d,
                          output logic drove, output logic ta_ok);
    logic any_oe;
    header(32, 2'b01, 2'b10, phy, rg);
    @(negedge clk); drv_en = 1'b0;
    ta_ok = !dut_oe;
    @(negedge clk);
    drove  = dut_oe;
    any_oe = dut_oe;
    ta_ok  = ta_ok && (!dut_oe || !dut_o);
    d = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      d = {d[14:0], line};
      any_oe = any_oe | dut_oe;
      if (drove && !dut_oe) ta_ok = 1'b0;
    end
    @(negedge clk);
    ta_ok = ta_ok && !dut_oe;
    drove = drove | any_oe;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 reset oe", dut_oe == 1'b0, dut_oe, 0);
    chk("R8 reset we", we == 1'b0, we, 0);
  endtask

  task automatic t_std_rw();
    logic [15:0] d; logic dr, ta; int c0;
    c0 = wr_cnt;
    wr_frame(2'b01, 5'd2, 5'd3, 16'hBEEF); settle();
    chk("R8 one strobe", wr_cnt == c0 + 1, wr_cnt - c0, 1);
    chk("R3 port address", last_addr == 8'h23, last_addr, 8'h23);
    chk("R8 write data", last_data == 16'hBEEF, last_data, 16'hBEEF);
    rd_frame(5'd2, 5'd3, d, dr, ta);
    chk("R7 read drove", dr, dr, 1);
    chk("R7 turnaround and release", ta, ta, 1);
    chk("R3 read data", d == 16'hBEEF, d, 16'hBEEF);
    rd_frame(5'd5, 5'd31, d, dr, ta);
    chk("R3 last port reg31", d == std_mem[8'h9F], d, std_mem[8'h9F]);
  endtask

  task automatic t_std_unsup();
    logic [15:0] d; logic dr, ta; int c0;
    c0 = wr_cnt;
    wr_frame(2'b01, 5'd1, 5'd7, 16'h5555); settle();
    chk("R4 no strobe unsupported", wr_cnt == c0, wr_cnt - c0, 0);
    rd_frame(5'd1, 5'd7, d, dr, ta);
    chk("R4 unsupported reads zero", dr && d == 16'h0000, d, 0);
    chk("R4 preload untouched", std_mem[8'h07] == 16'h1234, std_mem[8'h07], 16'h1234);
    rd_frame(5'd9, 5'd1, d, dr, ta);
    chk("R9 unmatched port not driven", !dr, dr, 0);
  endtask

  task automatic t_ext();
    logic [15:0] d; logic dr, ta; int c0;
    ext_mode = 1'b1;
    c0 = wr_cnt;
    wr_frame(2'b01, 5'b10111, 5'b00101, 16'hA55C); settle();
    chk("R5 ext address", last_addr == 8'hA5, last_addr, 8'hA5);
    chk("R6 ext write byte", wr_cnt == c0 + 1 && last_data == 16'h005C, last_data, 16'h005C);
    rd_frame(5'b00111, 5'b11111, d, dr, ta);
    chk("R6 ext read upper zero", dr && d == 16'h007E, d, 16'h007E);
    c0 = wr_cnt;
    wr_frame(2'b01, 5'b00101, 5'b00001, 16'h00FF); settle();
    chk("R5 bad signature no write", wr_cnt == c0, wr_cnt - c0, 0);
    rd_frame(5'b00101, 5'b00001, d, dr, ta);
    chk("R5 bad signature no drive", !dr, dr, 0);
    ext_mode = 1'b0;
    settle();
  endtask

  task automatic t_framing();
    int c0;
    c0 = wr_cnt;
    send(1'b0);
    header(31, 2'b01, 2'b01, 5'd1, 5'd0);
    send(1'b1); send(1'b0);
    for (int i = 15; i >= 0; i--) send(1'b0);
    @(negedge clk); drv_en = 1'b0; settle();
    chk("R1 short preamble discarded", wr_cnt == c0, wr_cnt - c0, 0);
    wr_frame(2'b11, 5'd1, 5'd0, 16'h0F0F); settle();
    chk("R2 opcode 11 ignored", wr_cnt == c0, wr_cnt - c0, 0);
    wr_frame(2'b00, 5'd1, 5'd0, 16'h0F0F); settle();
    chk("R2 opcode 00 ignored", wr_cnt == c0, wr_cnt - c0, 0);
    header(32, 2'b00, 2'b01, 5'd1, 5'd0);
    for (int i = 0; i < 18; i++) send(1'b0);
    @(negedge clk); drv_en = 1'b0; settle();
    chk("R10 bad start discarded", wr_cnt == c0, wr_cnt - c0, 0);
    wr_frame(2'b01, 5'd1, 5'd0, 16'h1357); settle();
    chk("R10 resync write", wr_cnt == c0 + 1 && last_data == 16'h1357, last_data, 16'h1357);
  endtask

  task automatic t_back_to_back();
    logic [15:0] d; logic dr, ta; int c0;
    c0 = wr_cnt;
    wr_frame(2'b01, 5'd4, 5'd29, 16'hC3A1);
    rd_frame(5'd4, 5'd29, d, dr, ta);
    chk("R8 strobe during next preamble", wr_cnt == c0 + 1, wr_cnt - c0, 1);
    chk("R7 back-to-back read", dr && ta && d == 16'hC3A1, d, 16'hC3A1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      std_mem[i] = 16'(i * 257 + 3);
      ext_mem[i] = 16'(16'hF000 | 16'(i));
    end
    std_mem[8'h07] = 16'h1234;
    ext_mem[8'h3F] = 16'hFF7E;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_std_rw();
    t_std_unsup();
    t_ext();
    t_framing();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule